// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block brings a powered-down secondary processor core into operation. It drives the core's control pins in a fixed order that keeps the core safe at every step. A one-cycle start pulse latches the entry address the core will fetch from. The block then does the following, in order:

1. Holds both of the core's resets.
2. Clears the L1 reset-disable control.
3. Blocks external debug access.
4. Releases an 8-bit power clamp as a thermometer-code ramp.
5. Waits for the supply to settle, then opens the power-off gate.
6. Waits again, then releases both resets at once.
7. Raises the debug power-up flag and pulses a wake event to the core.

Every wait is a parameter counted in clock cycles. A testbench can therefore use short waits, while silicon uses waits near 10 ms and 1 ms. While the sequence runs, `busy_o` is high and further start pulses are dropped. A synchronous reset returns every control output to its safe, powered-down value.

Top module: `core_wake_seq`

## Requirements
- R1: On an accepted start, `boot_addr_o` takes the value on `boot_addr_i`. It holds that value until the next accepted start. Reset clears it to 0.
- R2: A start pulse in idle is accepted on the clock edge that samples it. From that edge, `rst_ctl_o` is 0 (both core reset and power-on reset asserted) and `busy_o` is 1.
- R3: One cycle after the start is accepted, `l1_rst_dis_o` is cleared while the core is held in reset.
- R4: Two cycles after acceptance, `dbg_pwrup_o` is 0. This happens before the clamp ramp begins.
- R5: Three cycles after acceptance, `clamp_o` takes the values 0xFF, 0x7F, 0x3F, 0x1F, 0x0F, 0x07, 0x03, 0x01 and 0x00, in that order. Each value is held for exactly STEP_CYCLES cycles. Each step drops only the top set bit.
- R6: After 0x00 has been held for its STEP_CYCLES, a further LONG_SETTLE_CYCLES cycles pass before `pwr_gate_o` goes to 0. The gate never opens while the clamp is nonzero.
- R7: SHORT_SETTLE_CYCLES cycles after the gate opens, `rst_ctl_o` changes from 0 to 3 in a single step.
- R8: `dbg_pwrup_o` rises to 1 one cycle after `rst_ctl_o` becomes 3, and never while it is below 3.
- R9: One cycle after `dbg_pwrup_o` rises:
  - `wake_o` and `done_o` each pulse high for exactly one cycle, in the same cycle.
  - `busy_o` falls in that cycle.
  - A start sampled on the next edge is accepted.
- R10: A start pulse while `busy_o` is 1 has no effect on any output, including `boot_addr_o`.
- R11: A synchronous reset at any point puts the outputs in the safe state, and the block is idle afterwards. The safe state is:
  - `clamp_o` 0xFF
  - `pwr_gate_o` 1
  - `rst_ctl_o` 0
  - `dbg_pwrup_o` 0
  - `l1_rst_dis_o` 1
  - `busy_o`, `done_o` and `wake_o` 0
  - `boot_addr_o` 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to run the power-up sequence |
| boot_addr_i | input | ADDR_W | Entry address to latch on an accepted start |
| boot_addr_o | output | ADDR_W | Latched entry address for the secondary core |
| rst_ctl_o | output | 2 | Core reset controls; 0 holds both resets, 3 releases both |
| l1_rst_dis_o | output | 1 | L1 reset-disable control |
| clamp_o | output | CLAMP_W | Power clamp vector; all ones clamps fully |
| pwr_gate_o | output | 1 | Power-off gate; 1 keeps the core unpowered |
| dbg_pwrup_o | output | 1 | Debug power-up indicator to the core |
| wake_o | output | 1 | One-cycle wake event to the core |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A behavioural model counts cycles since the accepted start and derives every output from that count. The bench runs the sequence with these stimuli, each isolating a different fault class:
- A plain first run, starting from the reset values, checks the step order and every dwell length.
- A second start applied in the very cycle that `done_o` is high shows whether the block re-arms without losing a cycle. Because the gate is already open and the debug flag is already high, this run also shows that the block itself clears the debug flag and restarts the ramp, rather than relying on reset values.
- Stray start pulses, and a start held for several cycles, all during `busy_o` and each carrying a different address, expose any leak into the latched address or the timing.
- A reset applied in the middle of the ramp must return every output to the safe values.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HOLD,
        S_L1_CLR,
        S_DBG_OFF,
        S_RAMP,
        S_SETTLE_PWR,
        S_SETTLE_GATE,
        S_RELEASE,
        S_DBG_ON
    } seq_state_e;

    localparam logic [1:0] RST_HELD     = 2'b00;
    localparam logic [1:0] RST_RELEASED = 2'b11;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/core_wake_timer.sv
module core_wake_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/core_wake_ramp.sv
module core_wake_ramp #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] vec_o,
    output logic             empty_o
);
    logic [WIDTH-1:0] vec_d, vec_q;

    // Each bit takes its upper neighbour on a step, so the code stays thermometer.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_top
            always_comb begin
                if (arm_i)       vec_d[i] = 1'b1;
                else if (step_i) vec_d[i] = 1'b0;
                else             vec_d[i] = vec_q[i];
            end
        end else begin : g_low
            always_comb begin
                if (arm_i)       vec_d[i] = 1'b1;
                else if (step_i) vec_d[i] = vec_q[i+1];
                else             vec_d[i] = vec_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '1;
        end else begin
            vec_q <= vec_d;
        end
    end

    assign vec_o   = vec_q;
    assign empty_o = (vec_q == '0);
endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
    import core_wake_pkg::*;
#(
    parameter int ADDR_W              = 32,
    parameter int CLAMP_W             = 8,
    parameter int STEP_CYCLES         = 100,
    parameter int LONG_SETTLE_CYCLES  = 1000000,
    parameter int SHORT_SETTLE_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] boot_addr_i,
    output logic [ADDR_W-1:0] boot_addr_o,
    output logic [1:0]        rst_ctl_o,
    output logic              l1_rst_dis_o,
    output logic [CLAMP_W-1:0] clamp_o,
    output logic              pwr_gate_o,
    output logic              dbg_pwrup_o,
    output logic              wake_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MAX_WAIT = max3(STEP_CYCLES, LONG_SETTLE_CYCLES, SHORT_SETTLE_CYCLES);
    localparam int CNT_W    = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT);
    localparam logic [CNT_W-1:0] STEP_LOAD  = CNT_W'(STEP_CYCLES - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_SETTLE_CYCLES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [1:0]        rst_ctl;
        logic              l1_dis;
        logic              gate;
        logic              dbg;
        logic [ADDR_W-1:0] boot;
        logic              busy;
        logic              done;
        logic              wake;
    } seq_regs_t;

    localparam seq_regs_t REGS_SAFE = '{
        state:   S_IDLE,
        rst_ctl: RST_HELD,
        l1_dis:  1'b1,
        gate:    1'b1,
        dbg:     1'b0,
        boot:    '0,
        busy:    1'b0,
        done:    1'b0,
        wake:    1'b0
    };

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             ramp_arm;
    logic             ramp_step;
    logic             ramp_empty;

    core_wake_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    core_wake_ramp #(.WIDTH(CLAMP_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (ramp_arm),
        .step_i  (ramp_step),
        .vec_o   (clamp_o),
        .empty_o (ramp_empty)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.wake  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ramp_arm  = 1'b0;
        ramp_step = 1'b0;

        unique case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.state   = S_HOLD;
                    r_d.rst_ctl = RST_HELD;
                    r_d.boot    = boot_addr_i;
                    r_d.busy    = 1'b1;
                end
            end
            S_HOLD: begin
                r_d.l1_dis = 1'b0;
                r_d.state  = S_L1_CLR;
            end
            S_L1_CLR: begin
                r_d.dbg   = 1'b0;
                r_d.state = S_DBG_OFF;
            end
            S_DBG_OFF: begin
                ramp_arm  = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = STEP_LOAD;
                r_d.state = S_RAMP;
            end
            S_RAMP: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (ramp_empty) begin
                        tmr_val   = LONG_LOAD;
                        r_d.state = S_SETTLE_PWR;
                    end else begin
                        tmr_val   = STEP_LOAD;
                        ramp_step = 1'b1;
                    end
                end
            end
            S_SETTLE_PWR: begin
                if (tmr_expired) begin
                    r_d.gate  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = SHORT_LOAD;
                    r_d.state = S_SETTLE_GATE;
                end
            end
            S_SETTLE_GATE: begin
                if (tmr_expired) begin
                    r_d.rst_ctl = RST_RELEASED;
                    r_d.state   = S_RELEASE;
                end
            end
            S_RELEASE: begin
                r_d.dbg   = 1'b1;
                r_d.state = S_DBG_ON;
            end
            S_DBG_ON: begin
                r_d.wake  = 1'b1;
                r_d.done  = 1'b1;
                r_d.busy  = 1'b0;
                r_d.state = S_IDLE;
            end
            default: begin
                r_d = REGS_SAFE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_SAFE;
        end else begin
            r_q <= r_d;
        end
    end

    assign boot_addr_o  = r_q.boot;
    assign rst_ctl_o    = r_q.rst_ctl;
    assign l1_rst_dis_o = r_q.l1_dis;
    assign pwr_gate_o   = r_q.gate;
    assign dbg_pwrup_o  = r_q.dbg;
    assign wake_o       = r_q.wake;
    assign busy_o       = r_q.busy;
    assign done_o       = r_q.done;
endmodule

// File: rtl/core_wake_seq_chk.sv
module core_wake_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int CLAMP_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  boot_addr_o,
    input logic [1:0]         rst_ctl_o,
    input logic [CLAMP_W-1:0] clamp_o,
    input logic               pwr_gate_o,
    input logic               dbg_pwrup_o,
    input logic               wake_o,
    input logic               busy_o,
    input logic               done_o
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b1;
    end

    // R2: the cycle busy rises, both resets are held
    p_hold_on_start_r2: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        $rose(busy_o) |-> rst_ctl_o == 2'b00);

    // R5: the clamp changes only by dropping its top bit, or by re-arming to all ones
    p_clamp_step_r5: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        (clamp_o != $past(clamp_o)) |-> (clamp_o == ($past(clamp_o) >> 1) || clamp_o == '1));

    // R6: the gate opens only once the clamp is fully released
    p_gate_after_clamp_r6: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        $fell(pwr_gate_o) |-> clamp_o == '0);

    // R7: reset release needs the gate open
    p_release_after_gate_r7: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        (rst_ctl_o == 2'b11 && $past(rst_ctl_o) != 2'b11) |-> (!pwr_gate_o && clamp_o == '0));

    // R8: debug power-up follows reset release
    p_dbg_after_release_r8: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        $rose(dbg_pwrup_o) |-> rst_ctl_o == 2'b11);

    // R9: wake and done coincide and last one cycle
    p_wake_done_r9: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        wake_o == done_o);
    p_wake_single_r9: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        wake_o |=> !wake_o);

    // R10: starts seen while busy leave the latched address alone
    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        (busy_o && $past(busy_o)) |-> $stable(boot_addr_o));

    // R11: the cycle after reset shows the safe state
    p_reset_safe_r11: assert property (@(posedge clk) disable iff (rst || armed_q !== 1'b1)
        $past(rst) |-> (clamp_o == '1 && pwr_gate_o && rst_ctl_o == 2'b00 && !dbg_pwrup_o && !busy_o));
endmodule

bind core_wake_seq core_wake_seq_chk #(.ADDR_W(ADDR_W), .CLAMP_W(CLAMP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_addr_o (boot_addr_o),
    .rst_ctl_o   (rst_ctl_o),
    .clamp_o     (clamp_o),
    .pwr_gate_o  (pwr_gate_o),
    .dbg_pwrup_o (dbg_pwrup_o),
    .wake_o      (wake_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/core_wake_seq_tb_top.sv
module core_wake_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STEP  = 3;
    localparam int LONG  = 20;
    localparam int SHORT = 7;
    localparam int GATE_T = 3 + 9 * STEP + LONG;
    localparam int REL_T  = GATE_T + SHORT;
    localparam int WDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] boot_addr_i = '0;
    logic [31:0] boot_addr_o;
    logic [1:0]  rst_ctl_o;
    logic        l1_rst_dis_o;
    logic [7:0]  clamp_o;
    logic        pwr_gate_o, dbg_pwrup_o, wake_o, busy_o, done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    core_wake_seq #(
        .ADDR_W(32), .CLAMP_W(8), .STEP_CYCLES(STEP),
        .LONG_SETTLE_CYCLES(LONG), .SHORT_SETTLE_CYCLES(SHORT)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .boot_addr_i(boot_addr_i),
        .boot_addr_o(boot_addr_o), .rst_ctl_o(rst_ctl_o), .l1_rst_dis_o(l1_rst_dis_o),
        .clamp_o(clamp_o), .pwr_gate_o(pwr_gate_o), .dbg_pwrup_o(dbg_pwrup_o),
        .wake_o(wake_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: t counts edges since the accepted start, -1 when idle
    int          t = -1;
    logic [31:0] boot_e = '0;
    logic [1:0]  rst_e = 2'b00;
    logic        l1_e = 1'b1, gate_e = 1'b1, dbg_e = 1'b0;
    logic        wake_e = 1'b0, done_e = 1'b0, busy_e = 1'b0;
    logic [7:0]  clamp_e = 8'hFF;

    always @(negedge clk) begin
        bit in_rst;
        in_rst = rst;
        if (rst) begin
            t = -1; boot_e = '0; rst_e = 2'b00; l1_e = 1'b1; gate_e = 1'b1;
            dbg_e = 1'b0; wake_e = 1'b0; done_e = 1'b0; busy_e = 1'b0; clamp_e = 8'hFF;
        end else begin
            wake_e = 1'b0;
            done_e = 1'b0;
            if (t < 0) begin
                if (start_i) begin
                    t = 0; boot_e = boot_addr_i; rst_e = 2'b00; busy_e = 1'b1;
                end
            end else begin
                t++;
                if (t == 1) l1_e = 1'b0;
                if (t == 2) dbg_e = 1'b0;
                if (t >= 3 && t < 3 + 9 * STEP && ((t - 3) % STEP) == 0)
                    clamp_e = 8'(16'h00FF >> ((t - 3) / STEP));
                if (t == GATE_T) gate_e = 1'b0;
                if (t == REL_T) rst_e = 2'b11;
                if (t == REL_T + 1) dbg_e = 1'b1;
                if (t == REL_T + 2) begin
                    wake_e = 1'b1; done_e = 1'b1; busy_e = 1'b0; t = -1;
                end
            end
        end
        if (in_rst) begin
            chk(clamp_o == clamp_e && pwr_gate_o == gate_e && rst_ctl_o == rst_e &&
                dbg_pwrup_o == dbg_e && l1_rst_dis_o == l1_e && boot_addr_o == boot_e &&
                !busy_o && !wake_o && !done_o,
                "R11 safe state", {clamp_o, 3'b0, pwr_gate_o, 2'b0, rst_ctl_o, 3'b0, dbg_pwrup_o, 3'b0, busy_o, 8'h0},
                {clamp_e, 3'b0, gate_e, 2'b0, rst_e, 3'b0, dbg_e, 3'b0, busy_e, 8'h0});
        end else begin
            chk(boot_addr_o == boot_e, "R1 boot address", boot_addr_o, boot_e);
            chk(rst_ctl_o == rst_e, "R2/R7 reset control", 32'(rst_ctl_o), 32'(rst_e));
            chk(l1_rst_dis_o == l1_e, "R3 L1 reset-disable", 32'(l1_rst_dis_o), 32'(l1_e));
            chk(dbg_pwrup_o == dbg_e, "R4/R8 debug power-up", 32'(dbg_pwrup_o), 32'(dbg_e));
            chk(clamp_o == clamp_e, "R5 clamp vector", 32'(clamp_o), 32'(clamp_e));
            chk(pwr_gate_o == gate_e, "R6 power gate", 32'(pwr_gate_o), 32'(gate_e));
            chk(wake_o == wake_e, "R9 wake pulse", 32'(wake_o), 32'(wake_e));
            chk(done_o == done_e, "R9 done pulse", 32'(done_o), 32'(done_e));
            chk(busy_o == busy_e, "R10 busy", 32'(busy_o), 32'(busy_e));
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic pulse_start(input logic [31:0] addr);
        start_i = 1'b1;
        boot_addr_i = addr;
        tick(1);
        start_i = 1'b0;
        boot_addr_i = 32'h0BAD_0BAD;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", WDOG);
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(4);

        // First run from reset values (R1..R9)
        pulse_start(32'h8000_1000);
        tick(10);
        // R10: stray starts with other addresses while busy
        pulse_start(32'h1111_2222);
        tick(5);
        pulse_start(32'h3333_4444);
        while (!done_o) tick(1);
        chk(boot_addr_o == 32'h8000_1000, "R10 address kept after ignored starts",
            boot_addr_o, 32'h8000_1000);

        // R9: back-to-back start in the done cycle
        pulse_start(32'h4000_0040);
        chk(busy_o == 1'b1, "R9 restart accepted after done", 32'(busy_o), 32'd1);
        tick(20);

        // R11: reset in the middle of the ramp
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(3);
        chk(busy_o == 1'b0 && clamp_o == 8'hFF, "R11 idle after mid-run reset",
            {23'b0, busy_o, clamp_o}, 32'h0000_00FF);

        // Start held high for several cycles: only the first counts (R10)
        start_i = 1'b1;
        boot_addr_i = 32'hCAFE_0000;
        tick(1);
        boot_addr_i = 32'hCAFE_FFFF;
        tick(3);
        start_i = 1'b0;
        while (!done_o) tick(1);
        chk(boot_addr_o == 32'hCAFE_0000, "R10 held start latched once",
            boot_addr_o, 32'hCAFE_0000);
        tick(6);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule